// File: doc/BRIEF.md
# Synchronous Serial Master Shifter

This block is the master side of a plain three-wire synchronous serial link. Writing a 16-bit word through the write strobe starts a frame: the block produces 8 or 16 shift clocks, drives the outgoing bits most significant first on `mosi` and samples `miso` at the same time. The received word is then available on `rx_data`. The serial clock is made from the system clock by a programmable half-period divider.

Three control inputs are taken when a frame starts. One picks the frame width. One picks the level at which the clock rests. One picks the edge on which outgoing data moves. In both timing modes the first bit is on `mosi` before the first clock edge. When data moves on trailing edges, incoming bits are taken on leading edges. When data moves on leading edges, the first leading edge leaves the first bit in place, every later leading edge advances the data, and incoming bits are taken on trailing edges. A leading edge is the edge that takes the clock away from its resting level. `busy` marks a frame in progress and `done` pulses once when it completes.

Top module: `sio_master`

## Requirements
- R1: A `wr_en` pulse while `busy` is low starts a frame and `busy` is high from the next cycle. The frame contains exactly N leading and N trailing clock edges, with N = 16 when `frame_wide` = 1 and N = 8 when `frame_wide` = 0.
- R2: While `busy` is low, `sck` rests at the `idle_hi` value taken at the start of the most recent frame. After reset it rests at 0. Each frame ends with `sck` back at that level.
- R3: Bits leave most significant first, and the first bit is on `mosi` from the cycle after the write. In 8-bit frames only `wr_data[7:0]` is sent, starting with bit 7.
- R4: With `shift_lead` = 0, `mosi` changes on trailing edges and `miso` is taken on leading edges. With `shift_lead` = 1, `miso` is taken on trailing edges and `mosi` changes on every leading edge except the first.
- R5: Each clock half-period lasts `half_div` system cycles, and a value of 0 acts as 1. The first leading edge occurs `half_div` cycles after the write is accepted. `busy` stays high for 2·N·`half_div` cycles.
- R6: `rx_data` holds the last received frame, with the first bit received in its most significant used position. In 8-bit frames the bits fill `rx_data[7:0]` and `rx_data[15:8]` reads 0. `rx_data` is updated only when a frame completes.
- R7: `done` is high for exactly one cycle: the first cycle in which `busy` is low after a frame.
- R8: A write while `busy` is high is ignored and does not start another frame. Changes to `frame_wide`, `idle_hi`, `shift_lead` or `half_div` during a frame have no effect on that frame.
- R9: After reset `busy`, `done`, `sck` and `rx_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the transmit word |
| wr_data | input | 16 | Word to transmit |
| frame_wide | input | 1 | 1: 16-bit frame, 0: 8-bit frame |
| idle_hi | input | 1 | Resting level of the serial clock |
| shift_lead | input | 1 | 1: data moves on leading edges, 0: on trailing edges |
| half_div | input | DIV_W | Clock half-period in system cycles (0 acts as 1) |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial shift clock |
| mosi | output | 1 | Serial data out |
| rx_data | output | 16 | Last received word |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The case that is hardest to reach from the ports is a frame disturbed in flight. A new write arrives, and every control input is flipped, while the shifter is mid-frame, so the latched settings must carry the frame to the end unchanged. The stimulus does this on random frames. It pulses the strobe with the inverted word and inverts width, polarity and mode a few cycles after the start. The bench's slave model keeps following the original settings, and the checks then require the bit streams, edge counts and duration of the original frame. Directed frames at the shortest divider also cover all four polarity and mode pairs.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int EDGE_W = $clog2(2 * WORD_W);

    typedef logic [EDGE_W-1:0] edge_idx_t;

    // Settings captured when a frame starts
    typedef struct packed {
        logic wide;
        logic idle_hi;
        logic shift_lead;
    } sio_cfg_t;

    // What a clock edge does to the datapath
    typedef struct packed {
        logic sample;
        logic shift;
        logic last;
    } sio_act_t;

    function automatic edge_idx_t last_edge(input logic wide);
        return wide ? edge_idx_t'(2 * WORD_W - 1) : edge_idx_t'(2 * BYTE_W - 1);
    endfunction

    // Even edge index = leading edge, odd = trailing edge
    function automatic sio_act_t edge_act(input sio_cfg_t cfg, input edge_idx_t idx);
        sio_act_t a;
        logic     lead;
        lead   = ~idx[0];
        a.last = (idx == last_edge(cfg.wide));
        if (cfg.shift_lead) begin
            a.sample = ~lead;
            a.shift  = lead && (idx != '0);
        end else begin
            a.sample = lead;
            a.shift  = ~lead && ~a.last;
        end
        return a;
    endfunction

    // Short frames send the low byte from the top of the shifter
    function automatic logic [WORD_W-1:0] align_tx(input logic wide,
                                                   input logic [WORD_W-1:0] d);
        return wide ? d : {d[BYTE_W-1:0], {(WORD_W - BYTE_W){1'b0}}};
    endfunction

endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             run,
    input  logic [DIV_W-1:0] div_in,
    output logic             tick
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div_q - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= DIV_W'(1);
            cnt_q <= '0;
        end else if (start) begin
            div_q <= (div_in == '0) ? DIV_W'(1) : div_in;
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= tick ? '0 : cnt_q + DIV_W'(1);
        end
    end

    // R5: half-period counter stays below the latched divider
    a_r5_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q < div_q));

    // R5: a zero divider is never latched
    a_r5_div_nonzero: assert property (@(posedge clk) disable iff (rst)
        div_q != '0);

endmodule

// File: rtl/sio_shift.sv
module sio_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         shift,
    input  logic         sample,
    input  logic         miso,
    output logic         mosi,
    output logic [W-1:0] rx_next
);

    logic [W-1:0] tx_q;
    logic [W-1:0] rx_q;

    assign mosi    = tx_q[W-1];
    assign rx_next = sample ? {rx_q[W-2:0], miso} : rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
            rx_q <= '0;
        end else if (load) begin
            tx_q <= load_word;
            rx_q <= '0;
        end else begin
            if (shift)  tx_q <= {tx_q[W-2:0], 1'b0};
            if (sample) rx_q <= rx_next;
        end
    end

    // R3: outgoing bits move only on a load or a shift request
    a_r3_tx_hold: assert property (@(posedge clk) disable iff (rst)
        (!load && !shift) |=> $stable(tx_q));

endmodule

// File: rtl/sio_master.sv
module sio_master
    import sio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              frame_wide,
    input  logic              idle_hi,
    input  logic              shift_lead,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic [WORD_W-1:0] rx_data,
    output logic              busy,
    output logic              done
);

    logic              busy_q;
    logic              done_q;
    logic              sck_q;
    sio_cfg_t          cfg_q;
    edge_idx_t         edge_q;
    logic [WORD_W-1:0] rx_q;
    logic [WORD_W-1:0] rx_next;
    logic              start;
    logic              tick;
    sio_act_t          act;
    sio_cfg_t          cfg_in;

    assign start  = wr_en & ~busy_q;
    assign cfg_in = '{wide: frame_wide, idle_hi: idle_hi, shift_lead: shift_lead};
    assign act    = edge_act(cfg_q, edge_q);

    sio_baud #(.DIV_W(DIV_W)) u_baud (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .run    (busy_q),
        .div_in (half_div),
        .tick   (tick)
    );

    sio_shift #(.W(WORD_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (start),
        .load_word (align_tx(frame_wide, wr_data)),
        .shift     (tick & act.shift),
        .sample    (tick & act.sample),
        .miso      (miso),
        .mosi      (mosi),
        .rx_next   (rx_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            sck_q  <= 1'b0;
            cfg_q  <= '0;
            edge_q <= '0;
            rx_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                busy_q <= 1'b1;
                cfg_q  <= cfg_in;
                sck_q  <= idle_hi;
                edge_q <= '0;
            end else if (tick) begin
                sck_q  <= ~sck_q;
                edge_q <= edge_q + edge_idx_t'(1);
                if (act.last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    rx_q   <= rx_next;
                end
            end
        end
    end

    assign sck     = sck_q;
    assign rx_data = rx_q;
    assign busy    = busy_q;
    assign done    = done_q;

    // R2: clock rests at the latched polarity outside a frame
    a_r2_idle_level: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> (sck_q == cfg_q.idle_hi));

    // R1: edge index never passes the final edge of the frame
    a_r1_edge_bound: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (edge_q <= last_edge(cfg_q.wide)));

    // R7: done lasts one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R7: done accompanies the end of every frame
    a_r7_done_at_end: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> done_q);

    // R8: latched settings hold for the whole frame
    a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        busy_q |=> $stable(cfg_q));

endmodule

// File: tb/sio_master_bench.sv
module sio_master_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        frame_wide = 1'b1;
    logic        idle_hi = 1'b0;
    logic        shift_lead = 1'b0;
    logic [7:0]  half_div = 8'd1;
    logic        miso = 1'b0;
    logic        sck;
    logic        mosi;
    logic [15:0] rx_data;
    logic        busy;
    logic        done;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sio_master u_sio_master (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .frame_wide (frame_wide),
        .idle_hi    (idle_hi),
        .shift_lead (shift_lead),
        .half_div   (half_div),
        .miso       (miso),
        .sck        (sck),
        .mosi       (mosi),
        .rx_data    (rx_data),
        .busy       (busy),
        .done       (done)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input logic [15:0] w, input logic wide);
        return wide ? w : {8'h00, w[7:0]};
    endfunction

    task automatic run_frame(input logic [15:0] word, input logic [15:0] s_word,
                             input logic wide, input logic idl, input logic lead_mode,
                             input logic [7:0] dv, input logic disturb);
        int          nbits;
        int          top;
        int          sidx;
        int          lcnt;
        int          tcnt;
        int          cyc;
        int          first_lead;
        int          div_eff;
        logic        prev;
        logic        is_lead;
        logic [15:0] mcap;
        nbits   = wide ? 16 : 8;
        top     = nbits - 1;
        div_eff = (dv == 0) ? 1 : int'(dv);
        sidx = 0; lcnt = 0; tcnt = 0; mcap = '0; first_lead = -1;
        miso       = s_word[top];
        wr_data    = word;
        frame_wide = wide;
        idle_hi    = idl;
        shift_lead = lead_mode;
        half_div   = dv;
        wr_en      = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk(busy === 1'b1, "R1 busy after write", int'(busy), 1);
        chk(mosi === word[top], "R3 first bit placed", int'(mosi), int'(word[top]));
        prev = sck;
        cyc  = 0;
        while (busy === 1'b1 && cyc < 5000) begin
            cyc++;
            if (disturb && cyc == 2) begin
                wr_en = 1'b1; wr_data = ~word; frame_wide = ~wide;
                idle_hi = ~idl; shift_lead = ~lead_mode; half_div = dv + 8'd3;
            end
            if (disturb && cyc == 3) wr_en = 1'b0;
            @(negedge clk);
            if (sck !== prev) begin
                is_lead = (sck !== idl);
                if (is_lead) begin
                    if (first_lead < 0) first_lead = cyc;
                    if (lead_mode) begin
                        if (lcnt > 0) sidx++;
                    end else begin
                        mcap = {mcap[14:0], mosi};
                    end
                    lcnt++;
                end else begin
                    if (lead_mode) mcap = {mcap[14:0], mosi};
                    else sidx++;
                    tcnt++;
                end
                miso = (sidx <= top) ? s_word[top - sidx] : 1'b0;
                prev = sck;
            end
        end
        wr_en = 1'b0;
        chk(cyc == 2 * nbits * div_eff, "R5 busy length", cyc, 2 * nbits * div_eff);
        chk(first_lead == div_eff, "R5 first leading edge", first_lead, div_eff);
        chk(lcnt == nbits && tcnt == nbits, "R1 edge count", lcnt * 100 + tcnt, nbits * 101);
        chk(sck === idl, "R2 clock back at rest", int'(sck), int'(idl));
        chk(done === 1'b1, "R7 done at end", int'(done), 1);
        chk(rx_data === exp_word(s_word, wide), "R6 received word", int'(rx_data),
            int'(exp_word(s_word, wide)));
        chk(exp_word(mcap, wide) === exp_word(word, wide), "R4 sent bits vs mode",
            int'(exp_word(mcap, wide)), int'(exp_word(word, wide)));
        @(negedge clk);
        chk(done === 1'b0, "R7 done one cycle", int'(done), 0);
        chk(busy === 1'b0, "R8 no extra frame", int'(busy), 0);
        chk(sck === idl, "R2 rest level held", int'(sck), int'(idl));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(busy === 1'b0, "R9 busy reset", int'(busy), 0);
        chk(done === 1'b0, "R9 done reset", int'(done), 0);
        chk(sck === 1'b0, "R9 sck reset", int'(sck), 0);
        chk(rx_data === 16'h0, "R9 rx reset", int'(rx_data), 0);

        // Directed: all polarity/mode pairs at the shortest divider
        for (int m = 0; m < 4; m++) begin
            run_frame(16'hA53C, 16'h3CA5, 1'b1, m[0], m[1], 8'd1, 1'b0);
            run_frame(16'hFF81, 16'h00C3, 1'b0, m[0], m[1], 8'd1, 1'b0);
        end
        // Zero divider acts as one (R5), extreme patterns
        run_frame(16'hFFFF, 16'h0000, 1'b1, 1'b0, 1'b1, 8'd0, 1'b0);
        run_frame(16'h0001, 16'h8000, 1'b1, 1'b1, 1'b0, 8'd0, 1'b1);
        // Disturbed short frame at a longer divider (R8)
        run_frame(16'h12F0, 16'hBE7D, 1'b0, 1'b1, 1'b1, 8'd5, 1'b1);

        for (int i = 0; i < 40; i++) begin
            run_frame(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom),
                      1'($urandom), 8'($urandom_range(0, 4)), 1'($urandom));
            repeat ($urandom_range(0, 3)) @(negedge clk);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule